// File: doc/BRIEF.md
# Write-Update Snooping Line Controller

This block holds the coherence state and the single data word of one cache line frame in a shared-bus multiprocessor that keeps copies coherent by updating them. The frame has four states: empty (invalid), valid-exclusive (the only copy, equal to memory), shared (other caches may hold copies), and dirty (the only copy, memory stale). The processor side presents reads and writes together with a tag-match bit. Misses and writes to shared lines become bus commands. The snoop side watches commands from other caches and answers them in the same cycle.

A processor access that finds the line valid is finished locally, unless it is a write to a shared line. A read miss fetches the word with a read-block command. A write miss sends the word out with a write-block command, so memory and every other copy take it. A write to a shared line sends an update-block command. Once the grant arrives, the requester samples a wired-OR shared line. This signal tells it whether other copies exist, and so decides between the shared and the valid-exclusive state. A snooped command and a processor request can arrive in the same cycle. The snoop is handled first and the processor request waits. The bus arbiter sits outside this block and answers with a grant.

Top module: `upd_line_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0). No bus request, processor completion or snoop response is driven.
- R2: The state encoding is invalid 0, valid-exclusive 1, shared 2, dirty 3. The bus command encoding is none 0, read-block 1, write-block 2, update-block 3. A bus operation raises the request output in the cycle after the processor request is accepted. The request and its command stay steady until a cycle with the grant high.
- R3: A read with the line invalid or the tag missing issues read-block. After the grant the line holds the bus data. Its state becomes shared if the shared input was high in the grant cycle, and valid-exclusive otherwise. The processor completion is high in the following cycle and returns the bus data.
- R4: A read that hits a valid line completes one cycle after acceptance with the line's word. It makes no bus request and leaves state and data unchanged.
- R5: A write that hits a valid-exclusive or dirty line completes locally one cycle after acceptance, with no bus request. The line takes the word and becomes dirty.
- R6: A write that hits a shared line issues update-block carrying the new word. After the grant the line holds that word and stays shared.
- R7: A write miss issues write-block carrying the new word. After the grant the line holds that word. Its state is shared if the shared input was high, and valid-exclusive otherwise.
- R8: The shared response is driven combinationally in the same cycle as any snooped command whose tag matches a valid line.
- R9: A snooped read-block on a held line drives the supply output together with the line's word. The flush output is driven only when the line is dirty. On the next edge the line becomes shared and keeps its data.
- R10: A snooped write-block or update-block on a held line replaces the word with the snooped data. The line ends shared.
- R11: A snooped command that finds the line invalid or the tag missing drives no response and changes neither state nor data.
- R12: A processor request in the same cycle as a snooped command is not accepted in that cycle. It is taken on the first cycle free of snoops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor access request, held until completion |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_hit_i | input | 1 | Tag of the access matches this frame |
| cpu_wdata_i | input | DW | Write word |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DW | Read word (or written word on writes) |
| bus_req_o | output | 1 | Bus command pending |
| bus_cmd_o | output | 2 | Bus command code |
| bus_wdata_o | output | DW | Word carried by write-block and update-block |
| bus_gnt_i | input | 1 | Bus grant; the command completes in this cycle |
| bus_shared_i | input | 1 | Wired-OR shared response from other caches |
| bus_rdata_i | input | DW | Word returned for read-block |
| snp_cmd_i | input | 2 | Snooped command code from another cache |
| snp_hit_i | input | 1 | Snooped address matches this frame's tag |
| snp_wdata_i | input | DW | Word carried by a snooped write |
| snp_shared_o | output | 1 | This frame holds a copy of the snooped line |
| snp_supply_o | output | 1 | This frame supplies the data for a snooped read-block |
| snp_flush_o | output | 1 | Memory must also take the supplied word |
| snp_rdata_o | output | DW | Supplied word |
| line_state_o | output | 2 | Current line state |
| line_data_o | output | DW | Current line word |

## Verification
Several corner cases are targeted on purpose. A snooped read-block on a dirty line must flush as well as supply; a design that supplied without flushing would leave memory stale while the line dropped to shared. Write misses and read misses run with the shared response both high and low, so a design that ignored the response would wrongly settle valid-exclusive next to live copies. A processor read is made to collide with a snooped update. A design without snoop priority would complete one cycle early and return the old word instead of the freshly updated one. Random sequences also send snoops to empty frames and to mismatched tags, which must leave the frame untouched.

// File: rtl/upd_pkg.sv
`timescale 1ns/1ps
package upd_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_EXC = 2'd1,
        LS_SHD = 2'd2,
        LS_DRT = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDBLK  = 2'd1,
        BC_WRBLK  = 2'd2,
        BC_UPDBLK = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ACT_RD_HIT   = 3'd0,
        ACT_WR_LOCAL = 3'd1,
        ACT_WR_UPD   = 3'd2,
        ACT_RD_MISS  = 3'd3,
        ACT_WR_MISS  = 3'd4
    } cpu_act_e;

endpackage

// File: rtl/upd_snoop_resp.sv
`timescale 1ns/1ps
module upd_snoop_resp
    import upd_pkg::*;
#(
    parameter int DW = 32
) (
    input  line_st_e        st_i,
    input  logic [DW-1:0]   data_i,
    input  bus_cmd_e        cmd_i,
    input  logic            hit_i,
    input  logic [DW-1:0]   wdata_i,
    output logic            shared_o,
    output logic            supply_o,
    output logic            flush_o,
    output logic [DW-1:0]   rdata_o,
    output line_st_e        st_o,
    output logic [DW-1:0]   data_o
);

    logic holds;
    logic is_read;

    always_comb begin
        holds    = (st_i != LS_INV) && hit_i && (cmd_i != BC_NONE);
        is_read  = (cmd_i == BC_RDBLK);
        shared_o = holds;
        supply_o = holds && is_read;
        flush_o  = holds && is_read && (st_i == LS_DRT);
        rdata_o  = (holds && is_read) ? data_i : '0;
        st_o     = st_i;
        data_o   = data_i;
        if (holds) begin
            // every remote command leaves a held copy shared
            st_o = LS_SHD;
            if (!is_read) begin
                data_o = wdata_i;
            end
        end
    end

endmodule

// File: rtl/upd_cpu_decode.sv
`timescale 1ns/1ps
module upd_cpu_decode
    import upd_pkg::*;
(
    input  line_st_e  st_i,
    input  logic      hit_i,
    input  logic      wr_i,
    output cpu_act_e  act_o
);

    logic valid;

    always_comb begin
        valid = (st_i != LS_INV) && hit_i;
        if (!valid) begin
            act_o = wr_i ? ACT_WR_MISS : ACT_RD_MISS;
        end else if (!wr_i) begin
            act_o = ACT_RD_HIT;
        end else if (st_i == LS_SHD) begin
            act_o = ACT_WR_UPD;
        end else begin
            act_o = ACT_WR_LOCAL;
        end
    end

endmodule

// File: rtl/upd_line_ctrl.sv
`timescale 1ns/1ps
module upd_line_ctrl
    import upd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req_i,
    input  logic            cpu_wr_i,
    input  logic            cpu_hit_i,
    input  logic [DW-1:0]   cpu_wdata_i,
    output logic            cpu_done_o,
    output logic [DW-1:0]   cpu_rdata_o,
    output logic            bus_req_o,
    output logic [1:0]      bus_cmd_o,
    output logic [DW-1:0]   bus_wdata_o,
    input  logic            bus_gnt_i,
    input  logic            bus_shared_i,
    input  logic [DW-1:0]   bus_rdata_i,
    input  logic [1:0]      snp_cmd_i,
    input  logic            snp_hit_i,
    input  logic [DW-1:0]   snp_wdata_i,
    output logic            snp_shared_o,
    output logic            snp_supply_o,
    output logic            snp_flush_o,
    output logic [DW-1:0]   snp_rdata_o,
    output logic [1:0]      line_state_o,
    output logic [DW-1:0]   line_data_o
);

    typedef struct packed {
        line_st_e        st;
        logic [DW-1:0]   data;
        logic            busy;
        bus_cmd_e        cmd;
        logic [DW-1:0]   wdata;
        logic            done;
        logic [DW-1:0]   rdata;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    bus_cmd_e        snp_cmd;
    line_st_e        snp_st;
    logic [DW-1:0]   snp_data;
    cpu_act_e        cpu_act;
    logic            snp_active;
    line_st_e        fill_st;

    assign snp_cmd = bus_cmd_e'(snp_cmd_i);

    upd_snoop_resp #(.DW(DW)) u_snoop (
        .st_i     (ctl_q.st),
        .data_i   (ctl_q.data),
        .cmd_i    (snp_cmd),
        .hit_i    (snp_hit_i),
        .wdata_i  (snp_wdata_i),
        .shared_o (snp_shared_o),
        .supply_o (snp_supply_o),
        .flush_o  (snp_flush_o),
        .rdata_o  (snp_rdata_o),
        .st_o     (snp_st),
        .data_o   (snp_data)
    );

    upd_cpu_decode u_decode (
        .st_i  (ctl_q.st),
        .hit_i (cpu_hit_i),
        .wr_i  (cpu_wr_i),
        .act_o (cpu_act)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        snp_active = (snp_cmd != BC_NONE);
        fill_st    = bus_shared_i ? LS_SHD : LS_EXC;

        if (snp_active) begin
            // snooped command owns this cycle; processor side waits
            ctl_d.st   = snp_st;
            ctl_d.data = snp_data;
        end else if (ctl_q.busy) begin
            if (bus_gnt_i) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.cmd  = BC_NONE;
                unique case (ctl_q.cmd)
                    BC_RDBLK: begin
                        ctl_d.st    = fill_st;
                        ctl_d.data  = bus_rdata_i;
                        ctl_d.rdata = bus_rdata_i;
                    end
                    BC_WRBLK: begin
                        ctl_d.st    = fill_st;
                        ctl_d.data  = ctl_q.wdata;
                        ctl_d.rdata = ctl_q.wdata;
                    end
                    default: begin
                        ctl_d.st    = LS_SHD;
                        ctl_d.data  = ctl_q.wdata;
                        ctl_d.rdata = ctl_q.wdata;
                    end
                endcase
            end
        end else if (cpu_req_i && !ctl_q.done) begin
            unique case (cpu_act)
                ACT_RD_HIT: begin
                    ctl_d.done  = 1'b1;
                    ctl_d.rdata = ctl_q.data;
                end
                ACT_WR_LOCAL: begin
                    ctl_d.done  = 1'b1;
                    ctl_d.st    = LS_DRT;
                    ctl_d.data  = cpu_wdata_i;
                    ctl_d.rdata = cpu_wdata_i;
                end
                ACT_WR_UPD: begin
                    ctl_d.busy  = 1'b1;
                    ctl_d.cmd   = BC_UPDBLK;
                    ctl_d.wdata = cpu_wdata_i;
                end
                ACT_RD_MISS: begin
                    ctl_d.busy  = 1'b1;
                    ctl_d.cmd   = BC_RDBLK;
                end
                default: begin
                    ctl_d.busy  = 1'b1;
                    ctl_d.cmd   = BC_WRBLK;
                    ctl_d.wdata = cpu_wdata_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: LS_INV, data: '0, busy: 1'b0, cmd: BC_NONE,
                       wdata: '0, done: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_done_o   = ctl_q.done;
    assign cpu_rdata_o  = ctl_q.rdata;
    assign bus_req_o    = ctl_q.busy;
    assign bus_cmd_o    = ctl_q.cmd;
    assign bus_wdata_o  = ctl_q.wdata;
    assign line_state_o = ctl_q.st;
    assign line_data_o  = ctl_q.data;

endmodule

// File: rtl/upd_line_chk.sv
`timescale 1ns/1ps
module upd_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req_i,
    input logic       cpu_wr_i,
    input logic       cpu_hit_i,
    input logic       cpu_done_o,
    input logic       bus_req_o,
    input logic [1:0] bus_cmd_o,
    input logic       bus_gnt_i,
    input logic [1:0] snp_cmd_i,
    input logic       snp_hit_i,
    input logic       snp_shared_o,
    input logic       snp_supply_o,
    input logic       snp_flush_o,
    input logic [1:0] line_state_o
);

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_cmd_o));

    a_r3_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_gnt_i && snp_cmd_i == 2'd0
        |=> cpu_done_o && !bus_req_o && line_state_o != 2'd0);

    a_r5_local_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_i && cpu_wr_i && cpu_hit_i && !bus_req_o && !cpu_done_o &&
        snp_cmd_i == 2'd0 && (line_state_o == 2'd1 || line_state_o == 2'd3)
        |=> line_state_o == 2'd3 && !bus_req_o && cpu_done_o);

    a_r6_upd_stays_shared: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_cmd_o == 2'd3 && bus_gnt_i && snp_cmd_i == 2'd0
        |=> line_state_o == 2'd2);

    a_r8_shared_resp: assert property (@(posedge clk) disable iff (!rst_n)
        snp_cmd_i != 2'd0 && snp_hit_i && line_state_o != 2'd0 |-> snp_shared_o);

    a_r9_flush_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |-> line_state_o == 2'd3 && snp_supply_o && snp_cmd_i == 2'd1);

    a_r9_to_shared: assert property (@(posedge clk) disable iff (!rst_n)
        snp_cmd_i == 2'd1 && snp_hit_i && line_state_o != 2'd0 |=> line_state_o == 2'd2);

    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state_o == 2'd0 || !snp_hit_i) |-> !snp_shared_o && !snp_supply_o);

    a_r12_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        snp_cmd_i != 2'd0 && !bus_req_o |=> !bus_req_o && !cpu_done_o);

endmodule

bind upd_line_ctrl upd_line_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req_i    (cpu_req_i),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_hit_i    (cpu_hit_i),
    .cpu_done_o   (cpu_done_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd_o),
    .bus_gnt_i    (bus_gnt_i),
    .snp_cmd_i    (snp_cmd_i),
    .snp_hit_i    (snp_hit_i),
    .snp_shared_o (snp_shared_o),
    .snp_supply_o (snp_supply_o),
    .snp_flush_o  (snp_flush_o),
    .line_state_o (line_state_o)
);

// File: tb/upd_line_ctrl_tb.sv
`timescale 1ns/1ps
module upd_line_ctrl_tb;

    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_wr = 1'b0, cpu_hit = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [DW-1:0] bus_wdata;
    logic bus_gnt = 1'b0, bus_shared = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic [1:0] snp_cmd = 2'd0;
    logic snp_hit = 1'b0;
    logic [DW-1:0] snp_wdata = '0;
    logic snp_shared, snp_supply, snp_flush;
    logic [DW-1:0] snp_rdata;
    logic [1:0] line_state;
    logic [DW-1:0] line_data;

    upd_line_ctrl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_wr_i(cpu_wr), .cpu_hit_i(cpu_hit),
        .cpu_wdata_i(cpu_wdata), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_wdata_o(bus_wdata),
        .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared), .bus_rdata_i(bus_rdata),
        .snp_cmd_i(snp_cmd), .snp_hit_i(snp_hit), .snp_wdata_i(snp_wdata),
        .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_flush_o(snp_flush),
        .snp_rdata_o(snp_rdata), .line_state_o(line_state), .line_data_o(line_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    // reference model of the frame
    logic [1:0]    m_st = 2'd0;
    logic [DW-1:0] m_data = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] fill_state(input logic sh);
        return sh ? 2'd2 : 2'd1;
    endfunction

    task automatic cpu_op(input logic wr, input logic hit, input logic [31:0] wd,
                          input int dly, input logic sh, input logic [31:0] bd);
        logic valid;
        logic [1:0] ecmd;
        logic [31:0] erd;
        string tag;
        valid = (m_st != 2'd0) && hit;
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_hit = hit; cpu_wdata = wd;
        @(negedge clk);
        if (valid && (!wr || m_st != 2'd2)) begin
            tag = wr ? "R5" : "R4";
            check({tag, " local completion"}, cpu_done, 1);
            check({tag, " no bus request"}, bus_req, 0);
            if (!wr) begin
                check("R4 read data", cpu_rdata, m_data);
            end else begin
                m_st = 2'd3;
                m_data = wd;
            end
            cpu_req = 1'b0;
        end else begin
            ecmd = !valid ? (wr ? 2'd2 : 2'd1) : 2'd3;
            tag = (ecmd == 2'd1) ? "R3" : ((ecmd == 2'd2) ? "R7" : "R6");
            check("R2 bus request raised", bus_req, 1);
            check({tag, " bus command"}, bus_cmd, ecmd);
            check("R2 no early completion", cpu_done, 0);
            if (wr) check({tag, " bus write word"}, bus_wdata, wd);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                check("R2 request held", bus_req, 1);
                check("R2 command held", bus_cmd, ecmd);
            end
            bus_gnt = 1'b1; bus_shared = sh; bus_rdata = bd;
            @(negedge clk);
            bus_gnt = 1'b0; bus_shared = 1'b0;
            if (ecmd == 2'd1) begin
                m_st = fill_state(sh); m_data = bd; erd = bd;
            end else if (ecmd == 2'd2) begin
                m_st = fill_state(sh); m_data = wd; erd = wd;
            end else begin
                m_st = 2'd2; m_data = wd; erd = wd;
            end
            check({tag, " completion after grant"}, cpu_done, 1);
            check({tag, " returned word"}, cpu_rdata, erd);
            check({tag, " request dropped"}, bus_req, 0);
            cpu_req = 1'b0;
            tag = {tag, " "};
        end
        check({tag, " line state"}, line_state, m_st);
        check({tag, " line data"}, line_data, m_data);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic hit, input logic [31:0] d);
        logic holds;
        string tag;
        holds = (m_st != 2'd0) && hit && (cmd != 2'd0);
        tag = !holds ? "R11" : ((cmd == 2'd1) ? "R9" : "R10");
        @(negedge clk);
        snp_cmd = cmd; snp_hit = hit; snp_wdata = d;
        #1;
        check(holds ? "R8 shared response" : "R11 no shared response", snp_shared, holds);
        check({tag, " supply"}, snp_supply, holds && cmd == 2'd1);
        check({tag, " flush"}, snp_flush, holds && cmd == 2'd1 && m_st == 2'd3);
        if (holds && cmd == 2'd1) check("R9 supplied word", snp_rdata, m_data);
        @(negedge clk);
        snp_cmd = 2'd0; snp_hit = 1'b0;
        if (holds) begin
            m_st = 2'd2;
            if (cmd != 2'd1) m_data = d;
        end
        check({tag, " state after snoop"}, line_state, m_st);
        check({tag, " data after snoop"}, line_data, m_data);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state invalid", line_state, 0);
        check("R1 no bus request", bus_req, 0);
        check("R1 no completion", cpu_done, 0);
        check("R1 no snoop response", snp_shared, 0);

        cpu_op(1'b0, 1'b1, 32'h0, 0, 1'b0, 32'hA5A5_0001);  // read miss, alone -> EXC
        cpu_op(1'b0, 1'b1, 32'h0, 0, 1'b0, 32'h0);          // read hit
        snoop(2'd1, 1'b1, 32'h0);                           // remote read -> SHD
        cpu_op(1'b1, 1'b1, 32'h1111_2222, 2, 1'b0, 32'h0);  // write hit shared -> update
        snoop(2'd2, 1'b1, 32'h3333_4444);                   // remote write miss
        snoop(2'd3, 1'b0, 32'hDEAD_BEEF);                   // tag mismatch, ignored
        cpu_op(1'b1, 1'b0, 32'h5555_6666, 1, 1'b0, 32'h0);  // write miss alone -> EXC
        cpu_op(1'b1, 1'b1, 32'h7777_8888, 0, 1'b0, 32'h0);  // local write -> DRT
        snoop(2'd1, 1'b1, 32'h0);                           // dirty supply with flush
        cpu_op(1'b1, 1'b0, 32'h9999_AAAA, 0, 1'b1, 32'h0);  // write miss, shared -> SHD
        cpu_op(1'b0, 1'b0, 32'h0, 3, 1'b1, 32'hBBBB_CCCC);  // read miss, shared -> SHD

        // R12: processor read collides with a snooped update
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_hit = 1'b1;
        snp_cmd = 2'd3; snp_hit = 1'b1; snp_wdata = 32'hC0FF_EE00;
        #1;
        check("R8 shared response during collision", snp_shared, 1);
        @(negedge clk);
        snp_cmd = 2'd0; snp_hit = 1'b0;
        m_data = 32'hC0FF_EE00;
        check("R12 request waits for snoop", cpu_done, 0);
        check("R12 snoop data taken first", line_data, m_data);
        @(negedge clk);
        check("R12 request completes after snoop", cpu_done, 1);
        check("R12 read returns updated word", cpu_rdata, m_data);
        cpu_req = 1'b0;

        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 1) == 0) begin
                cpu_op(1'($urandom_range(0, 1)), $urandom_range(0, 3) != 0, $urandom,
                       int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom);
            end else begin
                snoop(2'($urandom_range(0, 3)), $urandom_range(0, 3) != 0, $urandom);
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule